// File: doc/BRIEF.md
# Synchronous Clock Stop Gating

This block sits between the dividers of a clock generator and its output pins. It takes one divided bus clock, which feeds a group of single-ended outputs, and one divided CPU clock, which feeds several differential pairs. It gates each output with a per-output enable, with a shared stop input for each family, and with a power-down input. The block runs on a fast sampling clock `clk`. The divided clocks arrive as levels, and every output is a registered copy of its source level. Because of this, a gate can be built so that it never cuts a pulse short.

Bus outputs stop low. The lowest `NFREE` bus outputs are free-running and ignore the bus stop. CPU pairs park with the true side high and the complement side undriven, which leaves an external termination to pull the complement low. A per-pair configuration bit chooses whether a pair obeys the CPU stop or keeps running. Power-down forces every output low and clears all gate state. Stop inputs and power-down are asynchronous pins, and each one passes through a synchroniser before use.

Top module: `clk_stop_gate`

## Requirements
- R1: With no stop, no power-down and all enables set, each bus output reproduces `bus_src`. Each pair drives `cpu_t` = `cpu_src` and `cpu_c` = inverted `cpu_src` with `cpu_c_oe` = 1.
- R2: While `bus_stop_n` is low, every bus output with index `NFREE` or above rests low. Bus outputs with index below `NFREE` keep toggling.
- R3: The bus stop is sampled on a rising edge of `bus_src` and takes effect at the following falling edge. Stop and enable changes never shorten a bus high phase: every high pulse on a bus output lasts exactly one full source high phase.
- R4: While `cpu_stop_n` is low, as seen on two successive rising edges of `cpu_src`, each pair whose `cpu_stoppable` bit is 1 parks after its next rising transition. A parked pair has `cpu_t` = 1, `cpu_c` = 0 and `cpu_c_oe` = 0.
- R5: A pair whose `cpu_stoppable` bit is 0 is free-running and keeps toggling while `cpu_stop_n` is low.
- R6: A CPU pair changes state only while its source is high, so every low phase on `cpu_t` lasts one full source low phase. Whenever `cpu_c_oe` is 1, `cpu_c` is the inverse of `cpu_t`.
- R7: A bus output whose `bus_en` bit is 0 is held low. The change takes effect only during a low phase.
- R8: A pair whose `cpu_en` bit is 0 is parked as in R4.
- R9: While `pd_n` is low (after synchronisation), every bus output and every `cpu_t` is low and every `cpu_c_oe` is 0.
- R10: After a stop or a power-down is released, each output restarts at a rising edge of its source with full-length pulses (no runt).
- R11: During reset, all outputs, including `cpu_c_oe`, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_src | input | 1 | Divided bus clock level |
| cpu_src | input | 1 | Divided CPU clock level |
| bus_stop_n | input | 1 | Asynchronous active-low bus group stop |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU pair stop |
| pd_n | input | 1 | Asynchronous active-low power-down |
| bus_en | input | NBUS | Per bus output enable, 1 = on |
| cpu_en | input | NCPU | Per pair enable, 1 = on |
| cpu_stoppable | input | NCPU | Per pair: 1 = obeys stop, 0 = free-running |
| bus_clk | output | NBUS | Gated bus clocks |
| cpu_t | output | NCPU | True side of each pair |
| cpu_c | output | NCPU | Complement side of each pair |
| cpu_c_oe | output | NCPU | Drive enable of each complement side |

## Verification
The bench asserts and releases stops, enables and power-down at arbitrary points in the source period. A pulse-length monitor checks every bus high phase and every CPU low phase. A gate that switched on the wrong phase would leave a shortened pulse that this monitor reports. A design that ignored the free-running subset or the per-pair stoppable bit would show zero edges on outputs that must keep toggling. A pair parked low, or with its complement still driven, fails the park-state checks. A restart that was not aligned to the source would produce a runt on release.

// File: rtl/csg_pkg.sv
package csg_pkg;
  typedef enum logic {GATE_SHUT = 1'b0, GATE_OPEN = 1'b1} gate_e;
  localparam int unsigned CSG_MIN_SYNC = 2;
endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned DEPTH = (STAGES < csg_pkg::CSG_MIN_SYNC) ? csg_pkg::CSG_MIN_SYNC : STAGES;
  logic [DEPTH-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {DEPTH{RST_VAL}};
    else     sh <= {sh[DEPTH-2:0], d};
  end

  assign q = sh[DEPTH-1];
endmodule

// File: rtl/csg_bus_gate.sv
module csg_bus_gate
  import csg_pkg::*;
#(
  parameter int unsigned NBUS  = 8,
  parameter int unsigned NFREE = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd_active,
  input  logic            src,
  input  logic            run_sync,
  input  logic [NBUS-1:0] en,
  output logic [NBUS-1:0] clk_out
);
  logic            src_prev;
  logic            run_smp;
  logic [NBUS-1:0] allow;
  gate_e           gate [NBUS];

  // stop level captured on each rising edge of the source
  always_ff @(posedge clk) begin
    if (rst) begin
      src_prev <= 1'b0;
      run_smp  <= 1'b1;
    end else begin
      src_prev <= src;
      if (src && !src_prev) run_smp <= run_sync;
    end
  end

  for (genvar i = 0; i < NBUS; i++) begin : g_out
    if (i < NFREE) begin : g_free
      assign allow[i] = en[i];
    end else begin : g_stop
      assign allow[i] = en[i] & run_smp;
    end

    // gate moves only while the source is low: no truncated high phase
    always_ff @(posedge clk) begin
      if (rst || pd_active) gate[i] <= GATE_SHUT;
      else if (!src)        gate[i] <= allow[i] ? GATE_OPEN : GATE_SHUT;
    end

    always_ff @(posedge clk) begin
      if (rst || pd_active) clk_out[i] <= 1'b0;
      else                  clk_out[i] <= src & (gate[i] == GATE_OPEN);
    end
  end
endmodule

// File: rtl/csg_cpu_gate.sv
module csg_cpu_gate
  import csg_pkg::*;
#(
  parameter int unsigned NCPU = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd_active,
  input  logic            src,
  input  logic            run_sync,
  input  logic [NCPU-1:0] en,
  input  logic [NCPU-1:0] stoppable,
  output logic [NCPU-1:0] t_out,
  output logic [NCPU-1:0] c_out,
  output logic [NCPU-1:0] c_oe
);
  logic       src_prev;
  logic [1:0] smp;
  logic       run;
  gate_e      gate [NCPU];

  // two successive rising-edge samples must both see the stop
  always_ff @(posedge clk) begin
    if (rst) begin
      src_prev <= 1'b0;
      smp      <= 2'b11;
    end else begin
      src_prev <= src;
      if (src && !src_prev) smp <= {smp[0], run_sync};
    end
  end

  assign run = |smp;

  for (genvar j = 0; j < NCPU; j++) begin : g_pair
    // gate moves only while the source is high: park keeps true high
    always_ff @(posedge clk) begin
      if (rst || pd_active) gate[j] <= GATE_SHUT;
      else if (src)         gate[j] <= (en[j] && (!stoppable[j] || run)) ? GATE_OPEN : GATE_SHUT;
    end

    always_ff @(posedge clk) begin
      if (rst || pd_active) begin
        t_out[j] <= 1'b0;
        c_out[j] <= 1'b0;
        c_oe[j]  <= 1'b0;
      end else if (gate[j] == GATE_OPEN) begin
        t_out[j] <= src;
        c_out[j] <= ~src;
        c_oe[j]  <= 1'b1;
      end else begin
        t_out[j] <= 1'b1;
        c_out[j] <= 1'b0;
        c_oe[j]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned NBUS        = 8,
  parameter int unsigned NFREE       = 2,
  parameter int unsigned NCPU        = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_src,
  input  logic            cpu_src,
  input  logic            bus_stop_n,
  input  logic            cpu_stop_n,
  input  logic            pd_n,
  input  logic [NBUS-1:0] bus_en,
  input  logic [NCPU-1:0] cpu_en,
  input  logic [NCPU-1:0] cpu_stoppable,
  output logic [NBUS-1:0] bus_clk,
  output logic [NCPU-1:0] cpu_t,
  output logic [NCPU-1:0] cpu_c,
  output logic [NCPU-1:0] cpu_c_oe
);
  logic bus_run_s, cpu_run_s, pd_n_s, pd_active;

  csg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_bus (
    .clk(clk), .rst(rst), .d(bus_stop_n), .q(bus_run_s));
  csg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cpu (
    .clk(clk), .rst(rst), .d(cpu_stop_n), .q(cpu_run_s));
  csg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pd (
    .clk(clk), .rst(rst), .d(pd_n), .q(pd_n_s));

  assign pd_active = ~pd_n_s;

  csg_bus_gate #(.NBUS(NBUS), .NFREE(NFREE)) u_bus (
    .clk(clk), .rst(rst), .pd_active(pd_active), .src(bus_src),
    .run_sync(bus_run_s), .en(bus_en), .clk_out(bus_clk));

  csg_cpu_gate #(.NCPU(NCPU)) u_cpu (
    .clk(clk), .rst(rst), .pd_active(pd_active), .src(cpu_src),
    .run_sync(cpu_run_s), .en(cpu_en), .stoppable(cpu_stoppable),
    .t_out(cpu_t), .c_out(cpu_c), .c_oe(cpu_c_oe));
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int unsigned NBUS = 8,
  parameter int unsigned NCPU = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            pd_active,
  input logic            bus_src,
  input logic            cpu_src,
  input logic [NBUS-1:0] bus_clk,
  input logic [NCPU-1:0] cpu_t,
  input logic [NCPU-1:0] cpu_c,
  input logic [NCPU-1:0] cpu_c_oe
);
  a_r9_powerdown_low: assert property (@(posedge clk) disable iff (rst)
    pd_active |=> (bus_clk == '0 && cpu_t == '0 && cpu_c_oe == '0));

  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    a_r3_no_bus_truncate: assert property (@(posedge clk) disable iff (rst)
      (bus_clk[i] && bus_src && !pd_active) |=> bus_clk[i]);
  end

  for (genvar j = 0; j < NCPU; j++) begin : g_cpu
    a_r4_park_true_high: assert property (@(posedge clk) disable iff (rst)
      !pd_active |=> (cpu_c_oe[j] || (cpu_t[j] && !cpu_c[j])));
    a_r6_complement: assert property (@(posedge clk) disable iff (rst)
      !pd_active |=> (!cpu_c_oe[j] || (cpu_c[j] != cpu_t[j])));
    a_r6_no_cpu_truncate: assert property (@(posedge clk) disable iff (rst)
      (!cpu_t[j] && cpu_c_oe[j] && !cpu_src && !pd_active) |=> !cpu_t[j]);
  end
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.NBUS(NBUS), .NCPU(NCPU)) u_chk (
  .clk(clk), .rst(rst), .pd_active(pd_active), .bus_src(bus_src),
  .cpu_src(cpu_src), .bus_clk(bus_clk), .cpu_t(cpu_t), .cpu_c(cpu_c),
  .cpu_c_oe(cpu_c_oe));

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;
  localparam int NBUS = 8, NFREE = 2, NCPU = 3;
  localparam int BUS_HALF = 4, CPU_HALF = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_src = 1'b0, cpu_src = 1'b0;
  logic bus_stop_n = 1'b1, cpu_stop_n = 1'b1, pd_n = 1'b1;
  logic [NBUS-1:0] bus_en = '1;
  logic [NCPU-1:0] cpu_en = '1, cpu_stoppable = '1;
  logic [NBUS-1:0] bus_clk;
  logic [NCPU-1:0] cpu_t, cpu_c, cpu_c_oe;

  int errors = 0, checks = 0;
  int bad_bus = 0, bad_cpu = 0, bad_cmp = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [2:0] ph = '0;

  int bus_rise [NBUS];
  int cpu_rise [NCPU];
  bit cpu_park [NCPU];

  always #10 clk = ~clk;

  clk_stop_gate #(.NBUS(NBUS), .NFREE(NFREE), .NCPU(NCPU)) u_dut (
    .clk(clk), .rst(rst), .bus_src(bus_src), .cpu_src(cpu_src),
    .bus_stop_n(bus_stop_n), .cpu_stop_n(cpu_stop_n), .pd_n(pd_n),
    .bus_en(bus_en), .cpu_en(cpu_en), .cpu_stoppable(cpu_stoppable),
    .bus_clk(bus_clk), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_c_oe(cpu_c_oe));

  // sources: bus high/low 4 cycles each, cpu 2 cycles each
  initial forever begin
    @(negedge clk);
    ph = ph + 3'd1;
    bus_src = ph[2];
    cpu_src = ph[1];
  end

  // pulse-length monitor (R3, R6, R10)
  initial begin
    int  blen [NBUS];
    bit  bvld [NBUS];
    int  clen [NCPU];
    bit  cvld [NCPU];
    logic [NBUS-1:0] bprev = '0;
    logic [NCPU-1:0] cprev = '0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NBUS; i++) begin
        if (!mon_on) bvld[i] = 1'b0;
        else if (bus_clk[i] && !bprev[i]) begin bvld[i] = 1'b1; blen[i] = 1; end
        else if (bus_clk[i]) blen[i]++;
        else if (bprev[i] && bvld[i] && blen[i] != BUS_HALF) bad_bus++;
      end
      for (int j = 0; j < NCPU; j++) begin
        if (!mon_on) cvld[j] = 1'b0;
        else begin
          if (!cpu_t[j] && cprev[j]) begin cvld[j] = 1'b1; clen[j] = 1; end
          else if (!cpu_t[j]) clen[j]++;
          else if (!cprev[j] && cvld[j] && clen[j] != CPU_HALF) bad_cpu++;
          if (cpu_c_oe[j] && cpu_c[j] == cpu_t[j]) bad_cmp++;
        end
      end
      bprev = bus_clk;
      cprev = cpu_t;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic observe(input int n);
    logic [NBUS-1:0] bp;
    logic [NCPU-1:0] cp;
    @(negedge clk);
    bp = bus_clk; cp = cpu_t;
    for (int i = 0; i < NBUS; i++) bus_rise[i] = 0;
    for (int j = 0; j < NCPU; j++) begin cpu_rise[j] = 0; cpu_park[j] = 1'b1; end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < NBUS; i++) if (bus_clk[i] && !bp[i]) bus_rise[i]++;
      for (int j = 0; j < NCPU; j++) begin
        if (cpu_t[j] && !cp[j]) cpu_rise[j]++;
        if (!(cpu_t[j] && !cpu_c[j] && !cpu_c_oe[j])) cpu_park[j] = 1'b0;
      end
      bp = bus_clk; cp = cpu_t;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pulses(input string req, input int b0, input int c0, input int m0);
    check(bad_bus == b0, req, "bus high pulse shortened", bad_bus - b0, 0);
    check(bad_cpu == c0, req, "cpu low pulse shortened", bad_cpu - c0, 0);
    check(bad_cmp == m0, req, "complement not inverse of true", bad_cmp - m0, 0);
  endtask

  task automatic t_reset;
    wait_cyc(4);
    check(bus_clk == '0, "R11", "bus_clk in reset", int'(bus_clk), 0);
    check(cpu_t == '0 && cpu_c == '0, "R11", "cpu pair in reset", int'({cpu_t, cpu_c}), 0);
    check(cpu_c_oe == '0, "R11", "cpu_c_oe in reset", int'(cpu_c_oe), 0);
    @(negedge clk) rst = 1'b0;
    wait_cyc(24);
    mon_on = 1'b1;
  endtask

  task automatic t_run;
    int b0 = bad_bus, c0 = bad_cpu, m0 = bad_cmp;
    observe(64);
    for (int i = 0; i < NBUS; i++) check(bus_rise[i] == 8, "R1", $sformatf("bus %0d edges", i), bus_rise[i], 8);
    for (int j = 0; j < NCPU; j++) check(cpu_rise[j] == 16, "R1", $sformatf("pair %0d edges", j), cpu_rise[j], 16);
    check(cpu_c_oe == '1, "R1", "cpu_c_oe running", int'(cpu_c_oe), (1 << NCPU) - 1);
    check_pulses("R6", b0, c0, m0);
  endtask

  task automatic t_bus_stop;
    int b0 = bad_bus, c0 = bad_cpu, m0 = bad_cmp;
    wait_cyc(3);
    bus_stop_n = 1'b0;
    wait_cyc(40);
    observe(64);
    for (int i = 0; i < NBUS; i++) begin
      int e = (i < NFREE) ? 8 : 0;
      check(bus_rise[i] == e, "R2", $sformatf("bus %0d edges while stopped", i), bus_rise[i], e);
    end
    check(bus_clk[NBUS-1:NFREE] == '0, "R2", "stopped bus level", int'(bus_clk[NBUS-1:NFREE]), 0);
    check(cpu_rise[0] == 16, "R2", "pair 0 unaffected by bus stop", cpu_rise[0], 16);
    wait_cyc(5);
    bus_stop_n = 1'b1;
    wait_cyc(40);
    observe(64);
    for (int i = 0; i < NBUS; i++) check(bus_rise[i] == 8, "R10", $sformatf("bus %0d after release", i), bus_rise[i], 8);
    check_pulses("R3", b0, c0, m0);
  endtask

  task automatic t_cpu_stop;
    int b0 = bad_bus, c0 = bad_cpu, m0 = bad_cmp;
    cpu_stoppable = 3'b101;
    wait_cyc(1);
    cpu_stop_n = 1'b0;
    wait_cyc(40);
    observe(64);
    check(cpu_park[0] && cpu_rise[0] == 0, "R4", "pair 0 parked", cpu_rise[0], 0);
    check(cpu_park[2] && cpu_rise[2] == 0, "R4", "pair 2 parked", cpu_rise[2], 0);
    check(cpu_rise[1] == 16 && cpu_c_oe[1], "R5", "free pair 1 edges", cpu_rise[1], 16);
    check(bus_rise[NBUS-1] == 8, "R4", "bus unaffected by cpu stop", bus_rise[NBUS-1], 8);
    wait_cyc(7);
    cpu_stop_n = 1'b1;
    wait_cyc(40);
    observe(64);
    for (int j = 0; j < NCPU; j++) check(cpu_rise[j] == 16, "R10", $sformatf("pair %0d after release", j), cpu_rise[j], 16);
    check_pulses("R6", b0, c0, m0);
    cpu_stoppable = '1;
  endtask

  task automatic t_enables;
    int b0 = bad_bus, c0 = bad_cpu, m0 = bad_cmp;
    wait_cyc(2);
    bus_en = 8'b1111_0110;
    cpu_en = 3'b110;
    wait_cyc(40);
    observe(64);
    check(bus_rise[0] == 0 && bus_clk[0] == 1'b0, "R7", "free bus 0 disabled", bus_rise[0], 0);
    check(bus_rise[3] == 0 && bus_clk[3] == 1'b0, "R7", "bus 3 disabled", bus_rise[3], 0);
    check(bus_rise[1] == 8, "R7", "bus 1 still enabled", bus_rise[1], 8);
    check(cpu_park[0], "R8", "disabled pair 0 parked", int'(cpu_park[0]), 1);
    check(cpu_rise[1] == 16, "R8", "pair 1 still enabled", cpu_rise[1], 16);
    wait_cyc(1);
    bus_en = '1;
    cpu_en = '1;
    wait_cyc(40);
    observe(64);
    check(bus_rise[0] == 8 && bus_rise[3] == 8, "R7", "bus re-enabled", bus_rise[3], 8);
    check(cpu_rise[0] == 16, "R8", "pair 0 re-enabled", cpu_rise[0], 16);
    check_pulses("R3", b0, c0, m0);
  endtask

  task automatic t_powerdown;
    int b0, c0, m0, bad = 0;
    mon_on = 1'b0;
    wait_cyc(5);
    pd_n = 1'b0;
    wait_cyc(8);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (bus_clk != '0 || cpu_t != '0 || cpu_c_oe != '0) bad++;
    end
    check(bad == 0, "R9", "samples with an output active in power-down", bad, 0);
    mon_on = 1'b1;
    b0 = bad_bus; c0 = bad_cpu; m0 = bad_cmp;
    wait_cyc(3);
    pd_n = 1'b1;
    wait_cyc(40);
    observe(64);
    check(bus_rise[NBUS-1] == 8, "R10", "bus after power-down", bus_rise[NBUS-1], 8);
    check(cpu_rise[2] == 16, "R10", "pair 2 after power-down", cpu_rise[2], 16);
    check_pulses("R10", b0, c0, m0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run();
    t_bus_stop();
    t_cpu_stop();
    t_enables();
    t_powerdown();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule